// File: doc/BRIEF.md
# I2C Target with Byte Register File

This block is an I2C target that gives a bus master access to a small file of byte registers. SCL and SDA come in from the pads and are resynchronised to a fast system clock. The block finds START, repeated START and STOP conditions on the bus. It matches a 7-bit device address and acknowledges the bytes it accepts. It shifts data in both directions, MSB first, and drives SDA through an open-drain enable.

A word pointer sets which register the master reaches. This pointer is volatile: it keeps its value from one transfer to the next. The master can use three transfers:
- A write: the first byte after the address loads the pointer, and the bytes after that are stored.
- A random read: a pointer write, then a repeated START with the read bit set.
- A current-address read: the read starts at whatever value the pointer already holds.

The rest of the chip reads and writes the same registers through a parallel port.

The system clock is assumed to run at least ten times faster than SCL. Clock stretching, 10-bit addressing and general call are not handled.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, `sda_oe` is 0, every register reads 8'h00 on the system port, and the word pointer is 0.
- R2: Only the device address `TGT_ADDR` (default 7'h68, sent as the upper 7 bits of the first byte, with the R/W bit in bit 0) is acknowledged. On any other address the target sends no ACK on that byte or on any later byte, and it changes no register until the next START or STOP.
- R3: After a matched address with R/W = 0, the next byte is acknowledged and loaded into the word pointer. It is not stored in a register.
- R4: In a write, each further byte is acknowledged and stored in the register the pointer selects. The pointer then advances by one at the falling SCL edge that ends that acknowledge clock.
- R5: After a matched address with R/W = 1, the target transmits the register at the pointer, MSB first. Used after a pointer write and a repeated START, this makes a random read.
- R6: In a read, a master ACK advances the pointer and starts the next byte. A master NACK leaves the pointer unchanged and releases SDA (`sda_oe` = 0) until the next START or STOP.
- R7: A read with no pointer write before it starts at the pointer value left by the previous transfer.
- R8: Whenever the pointer advances from `DEPTH-1` (7 by default), it goes to 0. This holds in both reads and writes.
- R9: When the pointer is `DEPTH` or more, write bytes are still acknowledged but are discarded, and reads return 8'h00. From such a value the pointer advances by one.
- R10: The system port writes register `sys_addr` with `sys_wdata` when `sys_we` is 1. `sys_rdata` shows register `sys_addr` combinationally. Bus reads see what the system port has written.
- R11: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | SCL as seen on the pad |
| sda_in | input | 1 | SDA as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| sys_we | input | 1 | System write enable |
| sys_addr | input | $clog2(DEPTH) | System register index |
| sys_wdata | input | 8 | System write data |
| sys_rdata | output | 8 | Register at `sys_addr` |

## Verification
Some properties are checked by the assertions on every cycle:
- the open-drain enable changes only while SCL is low;
- the pointer moves only by one step, wrapping from the last register to 0, except when it is loaded from a received byte;
- a master NACK never moves the pointer;
- SDA stays released after an address mismatch;
- the reset state is as R1 gives it.

Other behaviour only the bench scenarios can show. These are the byte values returned by random reads and current-address reads, and reads that cross the wrap point. They also include stores that land in the intended registers, discarded writes to pointers out of range, and a wrong address that leaves the register file untouched.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and helpers for the I2C register-file target.
// Assumes byte-wide registers and an 8-bit word pointer.
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,    // bus free or not yet addressed
        ST_RX,      // shifting a byte in from the master
        ST_RX_ACK,  // driving ACK for a received byte
        ST_TX,      // shifting a byte out to the master
        ST_TX_ACK,  // sampling the master's ACK/NACK
        ST_SKIP     // ignoring the bus until START/STOP
    } eng_state_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        RX_DEVADDR,
        RX_PTR,
        RX_DATA
    } rx_kind_t;

    // Pointer advance: wrap from the last register, plain +1 elsewhere
    function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p,
                                                   input logic [BYTE_W-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Two-flop synchroniser for SCL and SDA, with edge and bus-condition detect.
// Assumes clk runs at least 10x SCL so each level lasts several cycles.
// Idle bus (both high) is the reset value, so reset creates no false edge.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_prev;
    logic       sda_prev;
    logic       scl_now;

    // Synchronise both lines and keep the previous synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff   <= 2'b11;
            sda_ff   <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[0], scl_in};
            sda_ff   <= {sda_ff[0], sda_in};
            scl_prev <= scl_ff[1];
            sda_prev <= sda_ff[1];
        end
    end

    assign scl_now   = scl_ff[1];
    assign sda_lvl   = sda_ff[1];
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    // START: SDA falls while SCL stays high; STOP: SDA rises while SCL high
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_reg_bank.sv
// Byte register file shared by the bus engine and a system-side port.
// Assumes DEPTH is a power of two; out-of-range bus access is filtered
// by the engine. A system write takes priority over a bus write.
module i2c_reg_bank #(
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic [AW-1:0] bus_raddr,
    output logic [7:0]    bus_rdata,
    input  logic          sys_we,
    input  logic [AW-1:0] sys_addr,
    input  logic [7:0]    sys_wdata,
    output logic [7:0]    sys_rdata
);

    logic [7:0] regs [DEPTH];

    // Register storage with system-over-bus write priority
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (sys_we && sys_addr == AW'(i)) begin
                regs[i] <= sys_wdata;
            end else if (bus_we && bus_addr == AW'(i)) begin
                regs[i] <= bus_wdata;
            end
        end
    end

    assign bus_rdata = regs[bus_raddr];
    assign sys_rdata = regs[sys_addr];

endmodule

// File: rtl/i2c_tgt_engine.sv
// I2C target protocol engine: address match, ACK, byte shifting and the
// volatile word pointer. Works from synchronised edges; all SDA changes
// are issued at a detected SCL fall, so they land while SCL is low.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter  logic [6:0] TGT_ADDR = 7'h68,
    parameter  int         DEPTH    = 8,
    localparam int         AW       = $clog2(DEPTH),
    localparam logic [BYTE_W-1:0] LAST = BYTE_W'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    eng_state_t        state_q;
    rx_kind_t          kind_q;
    logic [2:0]        cnt_q;
    logic              full_q;
    logic              rw_q;
    logic              mack_q;
    logic              oe_q;
    logic [BYTE_W-1:0] rxsh_q;
    logic [BYTE_W-1:0] txsh_q;
    logic [BYTE_W-1:0] ptr_q;
    logic [BYTE_W-1:0] sel_ptr;
    logic [BYTE_W-1:0] byte_at_sel;

    // Read address: next pointer while deciding on the master's ACK
    always_comb begin
        sel_ptr     = (state_q == ST_TX_ACK) ? ptr_step(ptr_q, LAST) : ptr_q;
        rd_addr     = sel_ptr[AW-1:0];
        byte_at_sel = (sel_ptr <= LAST) ? rd_data : '0;
    end

    // Store a data byte at the end of its ACK clock, in range only
    assign wr_en   = (state_q == ST_RX_ACK) && scl_fall && !start_det && !stop_det &&
                     (kind_q == RX_DATA) && (ptr_q <= LAST);
    assign wr_addr = ptr_q[AW-1:0];
    assign wr_data = rxsh_q;
    assign sda_oe  = oe_q;

    // Protocol sequencing; START and STOP override every state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= RX_DEVADDR;
            cnt_q   <= '0;
            full_q  <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            oe_q    <= 1'b0;
            rxsh_q  <= '0;
            txsh_q  <= '0;
            ptr_q   <= '0;
        end else if (start_det) begin
            state_q <= ST_RX;
            kind_q  <= RX_DEVADDR;
            cnt_q   <= '0;
            full_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else if (stop_det) begin
            state_q <= ST_IDLE;
            full_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_RX: begin
                    if (scl_rise) begin
                        rxsh_q <= {rxsh_q[BYTE_W-2:0], sda_lvl};
                        cnt_q  <= cnt_q + 1'b1;
                        full_q <= (cnt_q == 3'd7);
                    end else if (scl_fall && full_q) begin
                        full_q <= 1'b0;
                        if (kind_q == RX_DEVADDR && rxsh_q[7:1] != TGT_ADDR) begin
                            state_q <= ST_SKIP;
                        end else begin
                            oe_q    <= 1'b1;
                            rw_q    <= rxsh_q[0];
                            state_q <= ST_RX_ACK;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        oe_q  <= 1'b0;
                        cnt_q <= '0;
                        case (kind_q)
                            RX_DEVADDR: begin
                                if (rw_q) begin
                                    txsh_q  <= byte_at_sel;
                                    oe_q    <= ~byte_at_sel[7];
                                    state_q <= ST_TX;
                                end else begin
                                    kind_q  <= RX_PTR;
                                    state_q <= ST_RX;
                                end
                            end
                            RX_PTR: begin
                                ptr_q   <= rxsh_q;
                                kind_q  <= RX_DATA;
                                state_q <= ST_RX;
                            end
                            default: begin
                                ptr_q   <= ptr_step(ptr_q, LAST);
                                state_q <= ST_RX;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == 3'd7) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_TX_ACK;
                        end else begin
                            txsh_q <= {txsh_q[BYTE_W-2:0], 1'b0};
                            oe_q   <= ~txsh_q[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            ptr_q   <= ptr_step(ptr_q, LAST);
                            txsh_q  <= byte_at_sel;
                            oe_q    <= ~byte_at_sel[7];
                            cnt_q   <= '0;
                            state_q <= ST_TX;
                        end else begin
                            state_q <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_regfile_target.sv
// Top level: I2C target over a byte register file with a system port.
// Assumes clk is at least 10x SCL and the pad logic turns sda_oe into an
// open-drain pull-down.
module i2c_regfile_target #(
    parameter  logic [6:0] TGT_ADDR = 7'h68,
    parameter  int         DEPTH    = 8,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    input  logic          sys_we,
    input  logic [AW-1:0] sys_addr,
    input  logic [7:0]    sys_wdata,
    output logic [7:0]    sys_rdata
);

    logic          sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic          bus_we;
    logic [AW-1:0] bus_addr, bus_raddr;
    logic [7:0]    bus_wdata, bus_rdata;

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine #(.TGT_ADDR(TGT_ADDR), .DEPTH(DEPTH)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (bus_rdata),
        .rd_addr   (bus_raddr),
        .wr_en     (bus_we),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .sda_oe    (sda_oe)
    );

    i2c_reg_bank #(.DEPTH(DEPTH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_raddr (bus_raddr),
        .bus_rdata (bus_rdata),
        .sys_we    (sys_we),
        .sys_addr  (sys_addr),
        .sys_wdata (sys_wdata),
        .sys_rdata (sys_rdata)
    );

endmodule

// File: rtl/i2c_tgt_chk.sv
// Assertion checker for the I2C register-file target, bound to the top.
// Observes the synchronised SCL level, the SDA enable and engine state.
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
#(
    parameter logic [7:0] LAST = 8'd7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       scl_fall,
    input logic       sda_oe,
    input logic [7:0] ptr,
    input eng_state_t state,
    input rx_kind_t   kind,
    input logic       mack
);

    // R1: one reset cycle leaves SDA released and the pointer at 0
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && ptr == '0));

    // R2: once the bus is being ignored, SDA is never pulled
    assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

    // R4: the pointer moves only by one step or by a pointer load
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |->
            ((ptr == ptr_step($past(ptr), LAST)) ||
             ($past(state) == ST_RX_ACK && $past(kind) == RX_PTR)));

    // R6: a master NACK leaves the pointer where it was
    assert_nack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && scl_fall && !mack) |=> $stable(ptr));

    // R8: an acknowledged read at the last register wraps to 0
    assert_read_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && scl_fall && mack && ptr == LAST) |=> (ptr == '0));

    // R11: the SDA enable only changes while SCL is low
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_lvl));

endmodule

bind i2c_regfile_target i2c_tgt_chk #(.LAST(8'(DEPTH - 1))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (u_sync.scl_now),
    .scl_fall (u_sync.scl_fall),
    .sda_oe   (sda_oe),
    .ptr      (u_engine.ptr_q),
    .state    (u_engine.state_q),
    .kind     (u_engine.kind_q),
    .mack     (u_engine.mack_q)
);

// File: tb/i2c_regfile_target_tb.sv
// Scoreboard bench: a bus-master model drives transfers, read bytes are
// compared by a monitor against a queue of expected values.
module i2c_regfile_target_tb;

    localparam int Q = 32;           // clk cycles per quarter SCL period
    localparam logic [7:0] DEV_W = 8'hD0;
    localparam logic [7:0] DEV_R = 8'hD1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       sys_we = 1'b0;
    logic [2:0] sys_addr = '0;
    logic [7:0] sys_wdata = '0;
    logic [7:0] sys_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    int r11_viol = 0;
    bit done     = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_byte;
    event       got_ev;

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_regfile_target u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .sys_we    (sys_we),
        .sys_addr  (sys_addr),
        .sys_wdata (sys_wdata),
        .sys_rdata (sys_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pop the expected byte as each read byte is produced
    initial begin
        forever begin
            @(got_ev);
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL scoreboard: actual %h expected none", got_byte);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got_byte !== e) begin
                    n_fails++;
                    $display("FAIL %s: actual %h expected %h", t, got_byte, e);
                end
            end
        end
    end

    // R11 watch: the enable must not change while the pad SCL is high
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && m_scl) r11_viol++;
        prev_oe <= sda_oe;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = ~sda_line;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_line;
            wq();
            m_scl = 1'b0;
        end
        got_byte = b;
        ->got_ev;
        wq();
        m_sda = ~m_ack;
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic sys_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        sys_we = 1'b1; sys_addr = a; sys_wdata = d;
        @(negedge clk);
        sys_we = 1'b0;
    endtask

    task automatic sys_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        sys_addr = a;
        @(negedge clk);
        check(req, sys_rdata, exp);
    endtask

    task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
        logic a;
        send_byte(b, a);
        check(req, {7'd0, a}, {7'd0, exp_ack});
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
        sys_chk(3'd3, 8'h00, "R1 reg3");

        // R2 R3 R4: pointer write to 2 then three data bytes
        bus_start();
        send_chk(DEV_W, 1'b1, "R2 address ack");
        send_chk(8'h02, 1'b1, "R3 pointer ack");
        send_chk(8'hA1, 1'b1, "R4 data ack");
        send_chk(8'hB2, 1'b1, "R4 data ack");
        send_chk(8'hC3, 1'b1, "R4 data ack");
        bus_stop();
        sys_chk(3'd2, 8'hA1, "R4 reg2");
        sys_chk(3'd3, 8'hB2, "R4 reg3");
        sys_chk(3'd4, 8'hC3, "R4 reg4");
        sys_chk(3'd1, 8'h00, "R3 pointer byte not stored");

        // R10 R7 R6: system write, then current-address reads with NACK
        sys_wr(3'd5, 8'h5A);
        bus_start();
        send_chk(DEV_R, 1'b1, "R2 read address ack");
        push_exp(8'h5A, "R7 current read");
        recv_byte(1'b0, b);
        check("R6 released after NACK", {7'd0, sda_oe}, 8'h00);
        bus_stop();
        bus_start();
        send_chk(DEV_R, 1'b1, "R2 read address ack");
        push_exp(8'h5A, "R6 NACK kept pointer");
        recv_byte(1'b0, b);
        bus_stop();

        // R5 R6 R8 R10: random read from 6 across the wrap
        sys_wr(3'd6, 8'h66);
        sys_wr(3'd7, 8'h77);
        sys_wr(3'd0, 8'h10);
        bus_start();
        send_chk(DEV_W, 1'b1, "R2 address ack");
        send_chk(8'h06, 1'b1, "R3 pointer ack");
        bus_start();
        send_chk(DEV_R, 1'b1, "R5 repeated start ack");
        push_exp(8'h66, "R5 random read");
        recv_byte(1'b1, b);
        push_exp(8'h77, "R6 ACK advances");
        recv_byte(1'b1, b);
        push_exp(8'h10, "R8 read wrap");
        recv_byte(1'b0, b);
        bus_stop();
        bus_start();
        send_chk(DEV_R, 1'b1, "R2 read address ack");
        push_exp(8'h10, "R8 pointer left at 0");
        recv_byte(1'b0, b);
        bus_stop();

        // R8: write across the wrap
        bus_start();
        send_chk(DEV_W, 1'b1, "R2 address ack");
        send_chk(8'h07, 1'b1, "R3 pointer ack");
        send_chk(8'hE7, 1'b1, "R8 data ack");
        send_chk(8'hE0, 1'b1, "R8 data ack");
        bus_stop();
        sys_chk(3'd7, 8'hE7, "R8 reg7");
        sys_chk(3'd0, 8'hE0, "R8 reg0 after wrap");

        // R9: pointer out of range
        bus_start();
        send_chk(DEV_W, 1'b1, "R2 address ack");
        send_chk(8'h20, 1'b1, "R3 pointer ack");
        send_chk(8'h99, 1'b1, "R9 discarded byte still acked");
        bus_stop();
        sys_chk(3'd0, 8'hE0, "R9 reg0 untouched");
        sys_chk(3'd1, 8'h00, "R9 reg1 untouched");
        bus_start();
        send_chk(DEV_R, 1'b1, "R2 read address ack");
        push_exp(8'h00, "R9 read out of range");
        recv_byte(1'b0, b);
        bus_stop();

        // R2: wrong address, later bytes ignored
        bus_start();
        send_chk(8'hA0, 1'b0, "R2 mismatch no ack");
        send_chk(8'h03, 1'b0, "R2 ignored byte");
        send_chk(8'h44, 1'b0, "R2 ignored byte");
        bus_stop();
        sys_chk(3'd3, 8'hB2, "R2 reg3 untouched");

        // R11: enable never changed with SCL high
        check("R11 oe change with SCL high", r11_viol[7:0], 8'h00);

        repeat (10) @(negedge clk);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule